// File: doc/BRIEF.md
# Programmed-I/O Data Port Read-Ahead and Write-Posting Buffer

This block sits between a host register bus and the parallel interface of a disk drive. Its job is to speed up programmed-I/O data transfers. Data-port writes are captured in a posting queue and completed toward the host at once. The queue then drains to the drive in the background. A data-port read that starts a sector goes to the drive as a demand read. After that, the block keeps fetching the rest of that sector into a read-ahead queue, so later host reads of the same sector are answered without touching the drive.

The block follows ordering rules for anything that is not a fast-path data access. A non-data register access, an access to the other channel, or any access on a channel whose speed-up bit is clear goes straight to the drive. Such an access waits until the posting queue is empty. Any access that is not served from the read-ahead queue cancels the read-ahead stream and drops the data it has fetched. This includes writes, non-data accesses, a change of access size, an access to the other channel, and an access on a disabled channel.

The host request is a valid/ready stream. Once `host_req_valid` is high, the host holds every request field stable until `host_req_ready` is seen high at a clock edge. There is no back-pressure on the response: `host_rsp_valid` is a one-cycle pulse that the host must take. The drive side is a request/acknowledge stream. The block holds `drv_valid` and every drive-side field until `drv_ready`. For reads, the drive supplies `drv_rdata` in the acknowledge cycle.

Top module: `pio_prefetch_post`

## Requirements
- R1: When the bit of `cfg_en` indexed by the channel is 0, every access on that channel goes to the drive. The host request is accepted in the same cycle the drive acknowledges it, and nothing is posted or read ahead for it.
- R2: The first data-port read (register index 0) of a sector on an enabled channel is a demand read. It is accepted in the cycle the drive acknowledges it, and it starts a read-ahead stream for that channel and access size.
- R3: While a stream is active, the block fetches the remaining data words of the sector into an 8-entry read-ahead queue. A host read with the same channel and size is served from that queue, with no drive cycle for that read.
- R4: The access size is 16 bits when `host_req_wide` is 0 and 32 bits when it is 1. A 16-bit access returns data in bits [15:0] with the upper bits zero. A read whose size differs from the stream's size cancels the stream and becomes a new demand read.
- R5: A data-port write on an enabled channel is accepted without waiting for the drive, as long as the posting queue has room.
- R6: Posted writes reach the drive in the order in which they were accepted, with their channel, size and data unchanged.
- R7: While the posting queue holds data, a request that is not a post of the same channel is held off until the queue is empty. This covers non-data accesses, accesses to the other channel, demand reads and disabled-channel accesses.
- R8: When the posting queue holds 8 entries, a new data-port write is held off until an entry drains.
- R9: A posted write or a non-data access cancels the read-ahead stream and empties the read-ahead queue.
- R10: A sector is `SECTOR_BYTES` bytes long. When all of its words have been handed to the host, the next data read is a demand read.
- R11: `wbuf_full`, `wbuf_empty`, `pbuf_full` and `pbuf_empty` show the occupancy of the posting queue and the read-ahead queue. After reset both queues are empty and `drv_valid` is 0.
- R12: Every accepted host read produces exactly one `host_rsp_valid` pulse in the cycle after it is accepted. Writes produce none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 2 | Per-channel speed-up enable |
| host_req_valid | input | 1 | Host request valid |
| host_req_ready | output | 1 | Host request accepted |
| host_req_write | input | 1 | 1 = write, 0 = read |
| host_req_chan | input | 1 | Channel select |
| host_req_reg | input | REG_W | Register index, 0 = data port |
| host_req_wide | input | 1 | 1 = 32-bit, 0 = 16-bit access |
| host_req_wdata | input | 32 | Write data |
| host_rsp_valid | output | 1 | Read data pulse |
| host_rsp_rdata | output | 32 | Read data |
| drv_valid | output | 1 | Drive cycle request |
| drv_ready | input | 1 | Drive cycle acknowledge |
| drv_write | output | 1 | Drive cycle direction |
| drv_chan | output | 1 | Drive cycle channel |
| drv_reg | output | REG_W | Drive cycle register index |
| drv_wide | output | 1 | Drive cycle size |
| drv_wdata | output | 32 | Drive write data |
| drv_rdata | input | 32 | Drive read data, valid with acknowledge |
| wbuf_full | output | 1 | Posting queue full |
| wbuf_empty | output | 1 | Posting queue empty |
| pbuf_full | output | 1 | Read-ahead queue full |
| pbuf_empty | output | 1 | Read-ahead queue empty |

## Verification
The assertions assume that the host holds a pending request and all its fields stable until it is accepted. They also assume that the drive's read data is valid in the acknowledge cycle. Given that, they can require the block's own drive request to stay stable while unacknowledged. The bench drives each request from a task that keeps the fields fixed until `host_req_ready` is sampled high. It answers drive reads combinationally from per-channel counters. It throttles acknowledges with a repeating pattern, plus a stall switch that is only changed just after a clock edge.

// File: rtl/pio_pf_pkg.sv
package pio_pf_pkg;
  localparam int PIO_DW = 32;

  typedef enum logic [1:0] {SRC_NONE, SRC_POST, SRC_PF, SRC_HOST} drv_src_e;

  typedef struct packed {
    logic              chan;
    logic              wide;
    logic [PIO_DW-1:0] data;
  } post_ent_t;

  function automatic logic [PIO_DW-1:0] size_mask(input logic wide, input logic [PIO_DW-1:0] d);
    return wide ? d : {{(PIO_DW-16){1'b0}}, d[15:0]};
  endfunction
endpackage

// File: rtl/pio_pf_fifo.sv
module pio_pf_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic         flush,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rp, wp;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp  <= '0;
      wp  <= '0;
      cnt <= '0;
    end else if (flush) begin
      rp  <= '0;
      wp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wp] <= din;
  end

  assign dout  = mem[rp];
  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);

  // R8: never written past capacity
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !flush) |-> !full);
  // R3: a hit only ever pops held data
  a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/pio_pf_drvmux.sv
module pio_pf_drvmux
  import pio_pf_pkg::*;
#(
  parameter int REG_W = 3
) (
  input  drv_src_e          src,
  input  post_ent_t         post_head,
  input  logic              pf_chan,
  input  logic              pf_wide,
  input  logic              h_write,
  input  logic              h_chan,
  input  logic [REG_W-1:0]  h_reg,
  input  logic              h_wide,
  input  logic [PIO_DW-1:0] h_wdata,
  output logic              valid,
  output logic              write,
  output logic              chan,
  output logic [REG_W-1:0]  regidx,
  output logic              wide,
  output logic [PIO_DW-1:0] wdata
);
  always_comb begin
    valid  = 1'b1;
    write  = 1'b0;
    chan   = 1'b0;
    regidx = '0;
    wide   = 1'b0;
    wdata  = '0;
    unique case (src)
      SRC_POST: begin
        write = 1'b1;
        chan  = post_head.chan;
        wide  = post_head.wide;
        wdata = post_head.data;
      end
      SRC_PF: begin
        chan = pf_chan;
        wide = pf_wide;
      end
      SRC_HOST: begin
        write  = h_write;
        chan   = h_chan;
        regidx = h_reg;
        wide   = h_wide;
        wdata  = h_wdata;
      end
      default: valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/pio_prefetch_post.sv
module pio_prefetch_post
  import pio_pf_pkg::*;
#(
  parameter int DEPTH        = 8,
  parameter int SECTOR_BYTES = 512,
  parameter int REG_W        = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_en,
  input  logic              host_req_valid,
  output logic              host_req_ready,
  input  logic              host_req_write,
  input  logic              host_req_chan,
  input  logic [REG_W-1:0]  host_req_reg,
  input  logic              host_req_wide,
  input  logic [PIO_DW-1:0] host_req_wdata,
  output logic              host_rsp_valid,
  output logic [PIO_DW-1:0] host_rsp_rdata,
  output logic              drv_valid,
  input  logic              drv_ready,
  output logic              drv_write,
  output logic              drv_chan,
  output logic [REG_W-1:0]  drv_reg,
  output logic              drv_wide,
  output logic [PIO_DW-1:0] drv_wdata,
  input  logic [PIO_DW-1:0] drv_rdata,
  output logic              wbuf_full,
  output logic              wbuf_empty,
  output logic              pbuf_full,
  output logic              pbuf_empty
);
  localparam int LW = $clog2(SECTOR_BYTES + 1);
  localparam int PE = $bits(post_ent_t);

  // read-ahead stream state
  logic          pf_active, pf_chan, pf_wide, pf_busy;
  logic [LW-1:0] pf_left;

  post_ent_t         wb_head, wb_in;
  logic [PIO_DW-1:0] pb_dout;
  logic              wb_push, wb_pop, pb_push, pb_pop, discard;
  drv_src_e          src;

  // request classification
  logic is_data, chan_en, req_post, req_hit, req_direct, post_ok, host_acc, demand;
  logic host_direct_want, pf_want, drv_ack;

  assign is_data    = (host_req_reg == '0);
  assign chan_en    = cfg_en[host_req_chan];
  assign req_post   = host_req_write && is_data && chan_en;
  assign req_hit    = !host_req_write && is_data && chan_en && pf_active &&
                      (pf_chan == host_req_chan) && (pf_wide == host_req_wide) &&
                      (!pbuf_empty || pf_left != '0);
  assign req_direct = !req_post && !req_hit;
  assign post_ok    = !wbuf_full && (wbuf_empty || wb_head.chan == host_req_chan);

  assign host_direct_want = host_req_valid && req_direct && wbuf_empty && !pf_busy;
  assign pf_want = pf_active && (pf_left != '0) && !pbuf_full && wbuf_empty &&
                   !(host_req_valid && req_direct);

  always_comb begin
    src = SRC_NONE;
    if (pf_busy)               src = SRC_PF;
    else if (!wbuf_empty)      src = SRC_POST;
    else if (host_direct_want) src = SRC_HOST;
    else if (pf_want)          src = SRC_PF;
  end

  pio_pf_drvmux #(.REG_W(REG_W)) u_mux (
    .src(src), .post_head(wb_head), .pf_chan(pf_chan), .pf_wide(pf_wide),
    .h_write(host_req_write), .h_chan(host_req_chan), .h_reg(host_req_reg),
    .h_wide(host_req_wide), .h_wdata(host_req_wdata),
    .valid(drv_valid), .write(drv_write), .chan(drv_chan), .regidx(drv_reg),
    .wide(drv_wide), .wdata(drv_wdata)
  );

  assign drv_ack = drv_valid && drv_ready;

  always_comb begin
    if (req_post)     host_req_ready = post_ok;
    else if (req_hit) host_req_ready = !pbuf_empty;
    else              host_req_ready = (src == SRC_HOST) && drv_ready;
  end

  assign host_acc = host_req_valid && host_req_ready;
  assign demand   = host_acc && req_direct && !host_req_write && is_data && chan_en;
  assign discard  = host_acc && !req_hit;
  assign wb_push  = host_acc && req_post;
  assign wb_pop   = (src == SRC_POST) && drv_ready;
  assign pb_pop   = host_acc && req_hit;
  assign pb_push  = (src == SRC_PF) && drv_ready && pf_active && !discard;

  assign wb_in = '{chan: host_req_chan, wide: host_req_wide, data: host_req_wdata};

  pio_pf_fifo #(.W(PE), .DEPTH(DEPTH)) u_post (
    .clk(clk), .rst_n(rst_n), .push(wb_push), .pop(wb_pop), .flush(1'b0),
    .din(wb_in), .dout(wb_head), .full(wbuf_full), .empty(wbuf_empty)
  );

  pio_pf_fifo #(.W(PIO_DW), .DEPTH(DEPTH)) u_ahead (
    .clk(clk), .rst_n(rst_n), .push(pb_push), .pop(pb_pop), .flush(discard),
    .din(size_mask(pf_wide, drv_rdata)), .dout(pb_dout),
    .full(pbuf_full), .empty(pbuf_empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_active <= 1'b0;
      pf_chan   <= 1'b0;
      pf_wide   <= 1'b0;
      pf_left   <= '0;
      pf_busy   <= 1'b0;
    end else begin
      pf_busy <= (src == SRC_PF) && !drv_ready;
      if (demand) begin
        pf_active <= 1'b1;
        pf_chan   <= host_req_chan;
        pf_wide   <= host_req_wide;
        pf_left   <= host_req_wide ? LW'(SECTOR_BYTES - 4) : LW'(SECTOR_BYTES - 2);
      end else if (discard) begin
        pf_active <= 1'b0;
      end else if (pb_push) begin
        pf_left <= pf_left - (pf_wide ? LW'(4) : LW'(2));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rsp_valid <= 1'b0;
      host_rsp_rdata <= '0;
    end else begin
      host_rsp_valid <= host_acc && !host_req_write;
      if (host_acc && !host_req_write)
        host_rsp_rdata <= req_hit ? pb_dout : size_mask(host_req_wide, drv_rdata);
    end
  end

  // R6: drive request held stable until acknowledged
  a_r6_drv_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_valid && !drv_ready) |=> (drv_valid &&
      $stable({drv_write, drv_chan, drv_reg, drv_wide, drv_wdata})));
  // R7: unrelated accesses only after posted data has drained
  a_r7_drain_first: assert property (@(posedge clk) disable iff (!rst_n)
    (host_acc && req_direct) |-> (wbuf_empty && drv_ack));
  // R12: a response pulse follows an accepted read
  a_r12_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    host_rsp_valid |-> $past(host_req_valid && host_req_ready && !host_req_write));
  // R11: flags never contradict
  a_r11_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !(wbuf_full && wbuf_empty) && !(pbuf_full && pbuf_empty));
endmodule

// File: tb/tb_pio_prefetch_post.sv
module tb_pio_prefetch_post;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int SECTOR = 64;

  logic        clk = 0, rst_n = 0;
  logic [1:0]  cfg_en = 2'b01;
  logic        host_req_valid = 0, host_req_write = 0, host_req_chan = 0, host_req_wide = 0;
  logic [2:0]  host_req_reg = 0;
  logic [31:0] host_req_wdata = 0;
  logic        host_req_ready, host_rsp_valid;
  logic [31:0] host_rsp_rdata;
  logic        drv_valid, drv_ready, drv_write, drv_chan, drv_wide;
  logic [2:0]  drv_reg;
  logic [31:0] drv_wdata, drv_rdata;
  logic        wbuf_full, wbuf_empty, pbuf_full, pbuf_empty;

  int checks = 0, errors = 0, cyc = 0, ph = 0;
  bit done = 0, stall_drv = 0;
  logic [15:0] rd_cnt [2];

  pio_prefetch_post #(.DEPTH(DEPTH), .SECTOR_BYTES(SECTOR), .REG_W(3)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  assign drv_ready = !stall_drv && (ph % 3 != 0);
  assign drv_rdata = (drv_reg == 0) ? {7'h68, drv_chan, 8'h00, rd_cnt[drv_chan]}
                                    : (32'hC0DE_0000 | 32'(drv_reg));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    ph  <= ph + 1;
    if (!rst_n) begin
      rd_cnt[0] <= 16'h0100;
      rd_cnt[1] <= 16'h0800;
    end else if (drv_valid && drv_ready && !drv_write && drv_reg == 0)
      rd_cnt[drv_chan] <= rd_cnt[drv_chan] + 16'd1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] msk(input logic w, input logic [31:0] d);
    return w ? d : {16'h0, d[15:0]};
  endfunction

  // behavioural reference model
  logic [33:0] mq [$];
  logic [31:0] pq [$];
  bit mstream = 0, mchan = 0, mwide = 0, last_direct = 0, exp_pend = 0;
  int mleft = 0;
  logic [31:0] exp_rsp = 0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit ack, acc, is_post, is_hit, dir_acc, en;
      chk(wbuf_full == (mq.size() == DEPTH), "R11", "wbuf_full", wbuf_full, mq.size());
      chk(wbuf_empty == (mq.size() == 0), "R11", "wbuf_empty", wbuf_empty, mq.size());
      chk(pbuf_empty == (pq.size() == 0), "R11", "pbuf_empty", pbuf_empty, pq.size());
      if (exp_pend) chk(host_rsp_valid && host_rsp_rdata == exp_rsp, "R12", "rsp data",
                        host_rsp_rdata, exp_rsp);
      else chk(!host_rsp_valid, "R12", "spurious rsp", host_rsp_valid, 0);
      exp_pend = 0;
      ack = drv_valid && drv_ready;
      acc = host_req_valid && host_req_ready;
      dir_acc = 0;
      if (ack && drv_write) begin
        if (mq.size() > 0) begin
          chk({drv_chan, drv_wide, drv_wdata} == mq[0], "R6", "posted order",
              {drv_chan, drv_wide, drv_wdata}, mq[0]);
          void'(mq.pop_front());
        end else chk(acc && host_req_write, "R1", "direct write w/o host", acc, 1);
      end
      if (acc) begin
        en = cfg_en[host_req_chan];
        is_post = host_req_write && host_req_reg == 0 && en;
        is_hit  = !host_req_write && host_req_reg == 0 && en && mstream &&
                  mchan == host_req_chan && mwide == host_req_wide && (pq.size() > 0 || mleft > 0);
        if (is_post) begin
          chk(mq.size() < DEPTH, "R8", "post when full", mq.size(), DEPTH);
          mq.push_back({host_req_chan, host_req_wide, host_req_wdata});
          mstream = 0; pq.delete();
          last_direct = 0;
        end else if (is_hit) begin
          chk(pq.size() > 0, "R3", "hit with empty queue", pq.size(), 1);
          if (pq.size() > 0) begin exp_rsp = pq.pop_front(); exp_pend = 1; end
          last_direct = 0;
        end else begin
          dir_acc = 1; last_direct = 1;
          chk(mq.size() == 0, "R7", "direct before drain", mq.size(), 0);
          chk(ack && drv_reg == host_req_reg && drv_write == host_req_write &&
              drv_chan == host_req_chan, "R2", "direct not on drive", ack, 1);
          if (!host_req_write) begin exp_rsp = msk(host_req_wide, drv_rdata); exp_pend = 1; end
          pq.delete();
          if (!host_req_write && host_req_reg == 0 && en) begin
            mstream = 1; mchan = host_req_chan; mwide = host_req_wide;
            mleft = SECTOR - (host_req_wide ? 4 : 2);
          end else mstream = 0;
        end
      end
      if (ack && !drv_write && drv_reg == 0 && !dir_acc && mstream) begin
        pq.push_back(msk(mwide, drv_rdata));
        mleft -= (mwide ? 4 : 2);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 50000 && !done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic host_op(input logic w, input logic ch, input logic [2:0] rg,
                         input logic wd, input logic [31:0] d, output int waits);
    @(posedge clk); #1;
    host_req_valid = 1; host_req_write = w; host_req_chan = ch;
    host_req_reg = rg; host_req_wide = wd; host_req_wdata = d;
    waits = 0;
    @(negedge clk);
    while (!host_req_ready) begin waits++; @(negedge clk); end
    @(posedge clk); #1;
    host_req_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    int w;
    idle(3); rst_n = 1;
    @(negedge clk);
    chk(wbuf_empty && pbuf_empty && !wbuf_full && !pbuf_full && !drv_valid && !host_rsp_valid,
        "R11", "reset state", {wbuf_empty, pbuf_empty, drv_valid}, 3'b110);

    // R5: posting completes with the drive stalled
    @(posedge clk); #1 stall_drv = 1;
    for (int i = 0; i < 3; i++) begin
      host_op(1, 0, 0, 1, 32'hA000_0000 + i, w);
      chk(w == 0, "R5", "posted write waited", w, 0);
    end
    @(negedge clk);
    chk(drv_valid && drv_write && !wbuf_empty, "R5", "drive still pending", drv_valid, 1);

    // R8: full queue stalls the ninth write
    for (int i = 3; i < 8; i++) host_op(1, 0, 0, 1, 32'hA000_0000 + i, w);
    @(negedge clk);
    chk(wbuf_full, "R8", "full after 8", wbuf_full, 1);
    fork
      host_op(1, 0, 0, 1, 32'hA000_0008, w);
      begin
        repeat (6) @(negedge clk);
        chk(host_req_valid && !host_req_ready, "R8", "ninth write accepted", host_req_ready, 0);
        @(posedge clk); #1 stall_drv = 0;
      end
    join
    idle(40);

    // R7: non-data access waits behind posted data
    stall_drv = 1;
    host_op(1, 0, 0, 0, 32'h0000_1234, w);
    host_op(1, 0, 0, 0, 32'h0000_5678, w);
    fork
      host_op(0, 0, 3, 0, 0, w);
      begin
        repeat (5) @(negedge clk);
        chk(!host_req_ready && drv_write, "R7", "non-data overtook posts", host_req_ready, 0);
        @(posedge clk); #1 stall_drv = 0;
      end
    join
    chk(last_direct == 1, "R7", "non-data went direct", last_direct, 1);

    // R7: other-channel post waits for drain
    cfg_en = 2'b11; stall_drv = 1;
    host_op(1, 0, 0, 1, 32'hBEEF_0001, w);
    fork
      host_op(1, 1, 0, 1, 32'hBEEF_0002, w);
      begin
        repeat (4) @(negedge clk);
        chk(!host_req_ready, "R7", "cross-channel post accepted", host_req_ready, 0);
        @(posedge clk); #1 stall_drv = 0;
      end
    join
    idle(20);

    // R2, R3, R10: demand then read-ahead over a whole sector
    host_op(0, 0, 0, 1, 0, w);
    chk(last_direct == 1, "R2", "demand read", last_direct, 1);
    idle(60);
    @(negedge clk);
    chk(pbuf_full, "R3", "read-ahead filled", pbuf_full, 1);
    for (int i = 0; i < SECTOR/4 - 1; i++) begin
      host_op(0, 0, 0, 1, 0, w);
      if (i == 0) chk(w == 0, "R3", "hit waited", w, 0);
      chk(last_direct == 0, "R3", "hit went to drive", last_direct, 0);
    end
    host_op(0, 0, 0, 1, 0, w);
    chk(last_direct == 1, "R10", "next sector demand", last_direct, 1);

    // R4: size change cancels stream
    idle(10);
    host_op(0, 0, 0, 0, 0, w);
    chk(last_direct == 1, "R4", "size change direct", last_direct, 1);
    idle(10);
    host_op(0, 0, 0, 0, 0, w);
    chk(last_direct == 0, "R4", "narrow stream hit", last_direct, 0);

    // R9: posted write and non-data access discard read-ahead
    idle(20);
    host_op(1, 0, 0, 0, 32'h0000_9999, w);
    @(negedge clk);
    chk(pbuf_empty, "R9", "write discard", pbuf_empty, 1);
    idle(10);
    host_op(0, 0, 0, 1, 0, w);
    chk(last_direct == 1, "R9", "read after write demand", last_direct, 1);
    idle(20);
    host_op(0, 0, 2, 1, 0, w);
    @(negedge clk);
    chk(pbuf_empty, "R9", "non-data discard", pbuf_empty, 1);
    host_op(0, 0, 0, 1, 0, w);
    chk(last_direct == 1, "R9", "read after non-data demand", last_direct, 1);

    // R1: disabled channel passes straight through
    cfg_en = 2'b01;
    for (int i = 0; i < 2; i++) begin
      host_op(0, 1, 0, 1, 0, w);
      chk(last_direct == 1, "R1", "disabled read direct", last_direct, 1);
    end
    idle(20);
    @(negedge clk);
    chk(pbuf_empty, "R1", "no read-ahead when disabled", pbuf_empty, 1);
    @(posedge clk); #1 stall_drv = 1;
    fork
      host_op(1, 1, 0, 1, 32'hD15A_0001, w);
      begin
        repeat (4) @(posedge clk);
        #1 stall_drv = 0;
      end
    join
    chk(w >= 4, "R1", "disabled write not posted", w, 4);

    idle(10);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule